// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits next to a simple in-order fetch unit. It makes a short run of instructions repeat a programmed number of times without any branch instruction in the loop body. Software programs three things before the loop starts: a loop-start register, a loop-end register and a 12-bit repeat count. A 2-bit body-size field is derived from them when the count is written. After that, the controller watches the program-counter value of every retiring instruction. When the last instruction of the body retires and repetitions remain, it raises a one-cycle redirect pulse with the target address.

The loop is recognised ahead of its end. The retiring PC value is the instruction address plus 4. Software writes the end register with the address of a detection instruction plus 4, so detection happens when the retiring PC equals the end register. For a body of four or more instructions, the detection instruction is the one three instructions before the last one, and the start register holds the first body address. For a body of one to three instructions, detection happens on the instruction just before the body, and the start register holds the body length (1, 2 or 3) instead of an address. Instructions are 2 bytes long.

Top module: `hwloop_ctrl`

## Requirements
- R1: While reset is asserted and at release, the count output, size output, redirect pulse and redirect address are all zero.
- R2: A set-count write loads the count output with the written value, visible in the cycle after the write.
- R3: A set-count write sets the size output to 2'b01, 2'b10 or 2'b11 when the start register holds 1, 2 or 3, and to 2'b00 otherwise. Writing the start or end register alone leaves the size output unchanged.
- R4: A retire whose PC equals the end register arms the loop when the retire is not a taken branch and the count is non-zero. With size 2'b00 the last body instruction is at (end register − 4) + 6.
- R5: A detection retire that is a taken branch, or that happens while the count is zero, leaves the loop unarmed. The later end instruction then causes no redirect and leaves the count unchanged.
- R6: With size 2'b00, when the armed last body instruction retires with a count of 2 or more, the count drops by one and the redirect address is the start register.
- R7: With size n = 1, 2 or 3, the last body instruction is at (end register − 4) + 2n and the redirect address is (end register − 4) + 2.
- R8: When the armed last body instruction retires with a count of 1, the count becomes 0, no redirect is issued and the loop disarms.
- R9: A set-count write in the same cycle as a loop-end retire wins: the count takes the written value, no redirect is issued and the loop disarms.
- R10: The redirect pulse is high for exactly the one cycle after an armed last-instruction retire, and at no other time.
- R11: A short loop keeps repeating without its detection instruction running again. A long loop is re-armed or disarmed at each pass's detection instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_wr_en | input | 1 | Write strobe for the loop-start register |
| start_wr_data | input | ADDR_W | Loop-start value (address, or 1..3 for a short body) |
| end_wr_en | input | 1 | Write strobe for the loop-end register |
| end_wr_data | input | ADDR_W | Detection address plus 4 |
| count_wr_en | input | 1 | Set-count strobe; also latches the size field |
| count_wr_data | input | CNT_W | Repeat count |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | ADDR_W | Retiring instruction address plus 4 |
| ret_taken | input | 1 | The retiring instruction took a branch |
| redirect_valid | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | ADDR_W | Redirect target address |
| count_out | output | CNT_W | Remaining repetitions |
| size_out | output | 2 | Body-size field |

## Verification
The assertions assume at most one retire per cycle. They also assume the start and end registers are not rewritten while a loop is armed, and that a count write always arrives separately from the register loads it depends on. The bench stimulus meets these assumptions by design. It produces a retiring PC stream that steps by 2 bytes and follows each redirect the model predicts. It loads registers only in idle cycles before a set-count write. The only same-cycle overlap it creates on purpose is a count write together with a loop-end retire, which is the case R9 covers.

// File: rtl/hwloop_pkg.sv
// Shared types for the hardware loop controller.
// Assumes fixed-length instructions and a retiring PC that runs 4 bytes ahead.
package hwloop_pkg;

    // Body-size code latched at set-count; nonzero codes give the body length
    typedef enum logic [1:0] {
        BODY_LONG  = 2'b00,
        BODY_ONE   = 2'b01,
        BODY_TWO   = 2'b10,
        BODY_THREE = 2'b11
    } body_e;

    // Instruction slots between the detection point and the last body instruction
    localparam int unsigned LONG_DET_SLOTS = 3;

    // Number of slots from detection to loop end for a given body code
    function automatic int unsigned slots_after_det(input body_e b);
        return (b == BODY_LONG) ? LONG_DET_SLOTS : int'(b);
    endfunction

endpackage

// File: rtl/hwloop_cfg.sv
// Loop configuration registers: start, end and the derived body-size code.
// Assumes the size code is sampled from the start register as it stands
// when the set-count strobe arrives (same-cycle start writes are not seen).
module hwloop_cfg
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr_en,
    input  logic [ADDR_W-1:0] start_wr_data,
    input  logic              end_wr_en,
    input  logic [ADDR_W-1:0] end_wr_data,
    input  logic              count_wr_en,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output body_e             body_q
);

    logic short_enc;

    // Start values 1..3 mark a short body rather than an address
    assign short_enc = (start_q[ADDR_W-1:2] == '0) && (start_q[1:0] != 2'b00);

    // Register writes and size-code capture at set-count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            body_q  <= BODY_LONG;
        end else begin
            if (start_wr_en) start_q <= start_wr_data;
            if (end_wr_en)   end_q   <= end_wr_data;
            if (count_wr_en) body_q  <= short_enc ? body_e'(start_q[1:0]) : BODY_LONG;
        end
    end

endmodule

// File: rtl/hwloop_match.sv
// Address comparators: finds the detection retire and the armed loop-end
// retire, and forms the redirect target. Purely combinational.
// Assumes ret_pc is the retiring instruction address plus 4.
module hwloop_match
    import hwloop_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 2
) (
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [ADDR_W-1:0] end_q,
    input  body_e             body_q,
    input  logic              armed_q,
    output logic              det_hit,
    output logic              end_hit,
    output logic [ADDR_W-1:0] target
);

    localparam logic [ADDR_W-1:0] PC_AHEAD = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] IBYTES   = ADDR_W'(INSTR_BYTES);

    logic [ADDR_W-1:0] det_addr;
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] ret_addr;

    // Derive detection, last-instruction and retiring addresses
    always_comb begin
        det_addr  = end_q - PC_AHEAD;
        last_addr = det_addr + ADDR_W'(slots_after_det(body_q)) * IBYTES;
        ret_addr  = ret_pc - PC_AHEAD;
    end

    // Hit detection and target selection
    always_comb begin
        det_hit = ret_valid && (ret_pc == end_q);
        end_hit = ret_valid && armed_q && (ret_addr == last_addr);
        target  = (body_q == BODY_LONG) ? start_q : det_addr + IBYTES;
    end

endmodule

// File: rtl/hwloop_seq.sv
// Repeat counter, arm state and registered redirect pulse.
// Assumes det_hit and end_hit are never high together (they are distinct
// addresses) and that at most one retire arrives per cycle.
module hwloop_seq #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_wr_en,
    input  logic [CNT_W-1:0]  count_wr_data,
    input  logic              det_hit,
    input  logic              ret_taken,
    input  logic              end_hit,
    input  logic [ADDR_W-1:0] target,
    output logic [CNT_W-1:0]  count_q,
    output logic              armed_q,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc
);

    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    // Priority: set-count, then loop end, then detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q        <= '0;
            armed_q        <= 1'b0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= 1'b0;
            if (count_wr_en) begin
                count_q <= count_wr_data;
                armed_q <= 1'b0;
            end else if (end_hit) begin
                if (count_q >= TWO) begin
                    count_q        <= count_q - CNT_W'(1);
                    redirect_valid <= 1'b1;
                    redirect_pc    <= target;
                end else begin
                    count_q <= '0;
                    armed_q <= 1'b0;
                end
            end else if (det_hit) begin
                armed_q <= !ret_taken && (count_q != '0);
            end
        end
    end

endmodule

// File: rtl/hwloop_ctrl.sv
// Top of the zero-overhead loop controller: configuration registers,
// address comparators and the count/redirect sequencer.
// Assumes a single in-order retire stream; no flush or exception handling.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 12,
    parameter int INSTR_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr_en,
    input  logic [ADDR_W-1:0] start_wr_data,
    input  logic              end_wr_en,
    input  logic [ADDR_W-1:0] end_wr_data,
    input  logic              count_wr_en,
    input  logic [CNT_W-1:0]  count_wr_data,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic              ret_taken,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [CNT_W-1:0]  count_out,
    output logic [1:0]        size_out
);

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] end_q;
    body_e             body_q;
    logic              armed_q;
    logic              det_hit;
    logic              end_hit;
    logic [ADDR_W-1:0] target;

    hwloop_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_wr_en   (start_wr_en),
        .start_wr_data (start_wr_data),
        .end_wr_en     (end_wr_en),
        .end_wr_data   (end_wr_data),
        .count_wr_en   (count_wr_en),
        .start_q       (start_q),
        .end_q         (end_q),
        .body_q        (body_q)
    );

    hwloop_match #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_match (
        .ret_valid (ret_valid),
        .ret_pc    (ret_pc),
        .start_q   (start_q),
        .end_q     (end_q),
        .body_q    (body_q),
        .armed_q   (armed_q),
        .det_hit   (det_hit),
        .end_hit   (end_hit),
        .target    (target)
    );

    hwloop_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .count_wr_en    (count_wr_en),
        .count_wr_data  (count_wr_data),
        .det_hit        (det_hit),
        .ret_taken      (ret_taken),
        .end_hit        (end_hit),
        .target         (target),
        .count_q        (count_out),
        .armed_q        (armed_q),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    // Expose the size code as a plain vector
    assign size_out = body_q;

endmodule

// File: rtl/hwloop_ctrl_chk.sv
// Temporal checks for hwloop_ctrl, attached with bind below.
// Assumes end register is not rewritten while a short loop redirect is pending.
module hwloop_ctrl_chk #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 12,
    parameter int INSTR_BYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              count_wr_en,
    input logic [CNT_W-1:0]  count_wr_data,
    input logic              ret_valid,
    input logic              ret_taken,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic [CNT_W-1:0]  count_out,
    input logic [1:0]        size_out,
    input logic              armed_q,
    input logic [ADDR_W-1:0] end_q
);

    // R6
    redirect_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> count_out == $past(count_out) - CNT_W'(1));

    // R8
    redirect_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(count_out) >= CNT_W'(2));

    // R9
    setcnt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_wr_en |=> (!redirect_valid && count_out == $past(count_wr_data) && !armed_q));

    // R3
    size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !count_wr_en |=> $stable(size_out));

    // R10
    redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ($past(ret_valid) && $past(armed_q)));

    // R5
    arm_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(ret_valid && !ret_taken && count_out != '0));

    // R7
    short_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && size_out != 2'b00)
            |-> redirect_pc == $past(end_q) - ADDR_W'(4) + ADDR_W'(INSTR_BYTES));

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .count_wr_en    (count_wr_en),
    .count_wr_data  (count_wr_data),
    .ret_valid      (ret_valid),
    .ret_taken      (ret_taken),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .count_out      (count_out),
    .size_out       (size_out),
    .armed_q        (armed_q),
    .end_q          (end_q)
);

// File: tb/test_hwloop_ctrl.sv
// Bench: behavioural reference model stepped alongside the design and
// compared every cycle; the retiring PC stream follows predicted redirects.
module test_hwloop_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr_en = 1'b0;
    logic [31:0] start_wr_data = '0;
    logic        end_wr_en = 1'b0;
    logic [31:0] end_wr_data = '0;
    logic        count_wr_en = 1'b0;
    logic [11:0] count_wr_data = '0;
    logic        ret_valid = 1'b0;
    logic [31:0] ret_pc = '0;
    logic        ret_taken = 1'b0;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [11:0] count_out;
    logic [1:0]  size_out;

    hwloop_ctrl i_hwloop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_wr_en(start_wr_en), .start_wr_data(start_wr_data),
        .end_wr_en(end_wr_en), .end_wr_data(end_wr_data),
        .count_wr_en(count_wr_en), .count_wr_data(count_wr_data),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_taken(ret_taken),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .count_out(count_out), .size_out(size_out)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int nred = 0;
    string cur_req = "R1";

    // reference model state
    longint m_start = 0, m_end = 0, m_cnt = 0, m_size = 0, m_tgt = 0;
    bit     m_armed = 0, m_red = 0;

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one clock: advance model from current inputs, then compare at negedge
    task automatic cycle();
        longint det, last, n;
        m_red = 0;
        det  = m_end - 4;
        n    = (m_size == 0) ? 3 : m_size;
        last = det + 2 * n;
        if (count_wr_en) begin
            m_cnt   = count_wr_data;
            m_size  = (m_start >= 1 && m_start <= 3) ? m_start : 0;
            m_armed = 0;
        end else if (ret_valid && m_armed && ((ret_pc - 4) & 32'hFFFF_FFFF) == last) begin
            if (m_cnt >= 2) begin
                m_cnt--;
                m_red = 1;
                m_tgt = (m_size == 0) ? m_start : det + 2;
            end else begin
                m_cnt   = 0;
                m_armed = 0;
            end
        end else if (ret_valid && ret_pc == m_end[31:0]) begin
            m_armed = !ret_taken && m_cnt > 0;
        end
        if (start_wr_en) m_start = start_wr_data;
        if (end_wr_en)   m_end   = end_wr_data;
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, redirect_valid, m_red, "redirect_valid");
        if (m_red) chk(cur_req, redirect_pc, m_tgt, "redirect_pc");
        chk(cur_req, count_out, m_cnt, "count_out");
        chk(cur_req, size_out, m_size, "size_out");
        if (redirect_valid) nred++;
        start_wr_en = 0; end_wr_en = 0; count_wr_en = 0;
        ret_valid = 0; ret_taken = 0;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] e, input int cnt);
        start_wr_en = 1; start_wr_data = s;
        end_wr_en = 1; end_wr_data = e;
        cycle();
        count_wr_en = 1; count_wr_data = 12'(cnt);
        cycle();
    endtask

    // retire n instructions from a0, following predicted redirects
    task automatic run(input logic [31:0] a0, input int n, input logic [31:0] br_addr);
        logic [31:0] a = a0;
        for (int i = 0; i < n; i++) begin
            ret_valid = 1; ret_pc = a + 4; ret_taken = (a == br_addr);
            cycle();
            a = m_red ? m_tgt[31:0] : a + 2;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", redirect_valid, 0, "redirect_valid");
        chk("R1", redirect_pc, 0, "redirect_pc");
        chk("R1", count_out, 0, "count_out");
        chk("R1", size_out, 0, "size_out");
        rst_n = 1;
        cycle();

        // R2 R3 R4 R6 R8: long loop 0x100..0x10A, detection at 0x104
        cur_req = "R2/R3";
        setup(32'h100, 32'h108, 3);
        chk("R2", count_out, 3, "count after set");
        chk("R3", size_out, 0, "size long body");
        cur_req = "R4/R6/R10";
        base = nred;
        run(32'h0FC, 24, 32'h0);
        chk("R6", nred - base, 2, "long loop redirects");
        chk("R8", count_out, 0, "count after last pass");

        // R7 R11: short loops of 1..3 instructions, detection at 0x200
        for (int n = 1; n <= 3; n++) begin
            cur_req = "R3";
            setup(32'(n), 32'h204, 4);
            chk("R3", size_out, n, "size short body");
            cur_req = "R7/R11";
            base = nred;
            run(32'h1FC, 4 + 4 * n + 2, 32'h0);
            chk("R11", nred - base, 3, "short loop redirects");
            chk("R8", count_out, 0, "short count end");
        end

        // R3: start/end loads alone leave size
        cur_req = "R3";
        start_wr_en = 1; start_wr_data = 32'h300;
        end_wr_en = 1; end_wr_data = 32'h308;
        cycle();
        cycle();
        chk("R3", size_out, 3, "size after plain load");

        // R5: taken branch at detection
        cur_req = "R5";
        setup(32'h100, 32'h108, 2);
        base = nred;
        run(32'h100, 8, 32'h104);
        chk("R5", nred - base, 0, "redirects after taken detect");
        chk("R5", count_out, 2, "count after taken detect");

        // R5: count zero at detection
        setup(32'h100, 32'h108, 0);
        base = nred;
        run(32'h100, 8, 32'h0);
        chk("R5", nred - base, 0, "redirects with zero count");

        // R9: set-count collides with loop-end retire
        cur_req = "R9";
        setup(32'h100, 32'h108, 5);
        run(32'h100, 5, 32'h0);
        ret_valid = 1; ret_pc = 32'h10A + 4;
        count_wr_en = 1; count_wr_data = 12'd9;
        cycle();
        chk("R9", redirect_valid, 0, "redirect on collision");
        chk("R9", count_out, 9, "count on collision");
        run(32'h10C, 4, 32'h0);

        // R11: long loop disarmed by taken branch at second pass detection
        cur_req = "R11";
        setup(32'h100, 32'h108, 3);
        base = nred;
        run(32'h100, 6, 32'h0);
        run(32'h100, 6, 32'h104);
        chk("R11", nred - base, 1, "long loop re-evaluated per pass");
        chk("R5", count_out, 2, "count after disarmed pass");

        cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule